// File: doc/BRIEF.md
# Centre-aligned dual-slope PWM timer

A 16-bit up/down timer that climbs from zero to a programmable TOP, turns, and descends back to zero, so every PWM period is symmetric about its midpoint. Two compare channels, A and B, each compare the running count with their own compare value and drive a waveform pin. The pin falls at the match on the way up and rises at the match on the way down (non-inverting), or does the opposite (inverting). Centre-aligned edges like these suit motor drives and other loads that gain from symmetric switching.

TOP comes either from a dedicated TOP input or from channel A's compare value. The compare values and the TOP value are double-buffered. The inputs hold the pending values, and the block copies them into its working registers at one fixed point of each period. In the frequency-correct variant that point is BOTTOM, so both slopes of a period always use the same TOP. In the phase-correct variant that point is TOP. A prescaler sets the tick rate, and the block gives one-clock strobes at the turning points.

Top module: `dspwm_timer`

## Requirements
- R1: Each prescaler tick moves the count by exactly one: up from 0 to TOP, then down to 0, repeating. Successive `bottom_evt` strobes are 2·N·TOP clocks apart, where N is the division ratio.
- R2: `clk_sel` encoding: 1, 2, 3, 4, 5 give N = 1, 8, 64, 256, 1024. Values 0, 6 and 7 stop the timer, and the count holds its value.
- R3: `mode` encoding: 8 is frequency-correct with TOP from `top_in`, 9 is frequency-correct with TOP from channel A's compare value, 10 is phase-correct with TOP from `top_in`, and 11 is phase-correct with TOP from channel A's compare value. Any other value holds the count.
- R4: With compare-output bits 2 (non-inverting) and compare value C, the pin is high for 2·N·C clocks of every period when 0 < C < TOP. It stays low when C = 0 and stays high when C ≥ TOP.
- R5: With compare-output bits 3 (inverting), the pin is high for 2·N·TOP minus the R4 high time, which is the R4 waveform complemented.
- R6: Compare-output bits 0 hold the pin low. Bits 1 hold it low, except on channel A when TOP comes from channel A's compare value (mode 9 or 11). In that case the pin toggles at every TOP, giving a 50% duty and a period of 4·N·TOP clocks.
- R7: In modes 8 and 9 the buffered TOP and compare values are loaded only at BOTTOM. A TOP change made mid-period leaves that period at the old length, and the following period is 2·N·TOP_new.
- R8: In modes 10 and 11 the buffered values are loaded only at TOP. After a change, the interval between two `top_evt` strobes is N·(TOP_old + TOP_new).
- R9: While the timer is stopped (per R2 or R3), the buffered values are copied into the working registers on every clock.
- R10: A TOP value below 3 is used as 3.
- R11: `top_evt` is high for one clock, on the tick that leaves TOP. `bottom_evt` is high for one clock, on the downward tick that leaves 0. On the clock after `bottom_evt`, the count is 1.
- R12: After reset, the count is 0, both pins are low and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_sel | input | 3 | Prescaler select (R2) |
| mode | input | 4 | Waveform mode (R3) |
| com_a | input | 2 | Channel A compare-output bits |
| com_b | input | 2 | Channel B compare-output bits |
| top_in | input | 16 | Pending TOP value |
| cmp_a_in | input | 16 | Pending compare value, channel A |
| cmp_b_in | input | 16 | Pending compare value, channel B |
| wave_a | output | 1 | Waveform pin, channel A |
| wave_b | output | 1 | Waveform pin, channel B |
| count | output | 16 | Current counter value |
| top_evt | output | 1 | Strobe on leaving TOP |
| bottom_evt | output | 1 | Strobe on leaving BOTTOM |

## Verification
On every cycle, the assertions check the following:
- the count steps by exactly one per tick and holds when there is no tick;
- the count restarts upward after BOTTOM and turns downward after TOP;
- a disconnected pin is low, and the zero and full compare extremes give fixed pin levels;
- the working registers stay unchanged outside the load point of the selected variant.

Only the bench scenarios can show the quantities that take a whole period to build up:
- the period length for each prescaler ratio;
- the exact high time for a given compare value;
- the 50% toggle waveform;
- the different period lengths that the two variants produce after a TOP change while the timer runs.

// File: rtl/dspwm_pkg.sv
// Shared constants and types for the dual-slope PWM timer.
package dspwm_pkg;
    localparam int CNT_W   = 16;   // counter and compare width
    localparam int PRE_W   = 10;   // prescaler counter width (largest ratio 1024)
    localparam int MIN_TOP = 3;    // smallest usable TOP

    typedef logic [1:0] com_t;
    localparam com_t COM_OFF    = 2'd0;
    localparam com_t COM_TOGGLE = 2'd1;
    localparam com_t COM_NONINV = 2'd2;
    localparam com_t COM_INV    = 2'd3;
endpackage

// File: rtl/dspwm_prescale.sv
// Clock-enable prescaler. It produces a one-clock tick every N clocks, where
// N is picked by sel (1,8,64,256,1024). Any other sel value gives no tick
// and resets the divider. Assumes PRE_W is at least 10.
module dspwm_prescale #(
    parameter int PRE_W = dspwm_pkg::PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick,
    output logic       valid
);
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic [3:0]       shift;

    // Decode the division ratio into a shift count.
    always_comb begin
        valid = 1'b1;
        case (sel)
            3'd1:    shift = 4'd0;
            3'd2:    shift = 4'd3;
            3'd3:    shift = 4'd6;
            3'd4:    shift = 4'd8;
            3'd5:    shift = 4'd10;
            default: begin shift = 4'd0; valid = 1'b0; end
        endcase
        mask = (ONE << shift) - ONE;
    end

    // Free-running divider, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)     pre_q <= '0;
        else if (valid) pre_q <= pre_q + ONE;
        else            pre_q <= '0;
    end

    assign tick = valid & ((pre_q & mask) == mask);

    // Divide-by-8 never gives ticks on two clocks in a row.
    assert_div8_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd2 && $past(sel) == 3'd2 && tick) |-> !$past(tick));
endmodule

// File: rtl/dspwm_updown.sv
// Dual-slope counter. On each step it counts up to top_val, turns, and counts
// down to zero. It flags the step that leaves TOP and the downward step that
// leaves zero. Assumes top_val >= 3.
module dspwm_updown #(
    parameter int W = dspwm_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] count_o,
    output logic         dir_up_o,
    output logic         top_evt_o,
    output logic         bottom_evt_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic         up_q;

    // Advance, or turn at the ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (step) begin
            if (up_q) begin
                if (cnt_q >= top_val) begin
                    up_q  <= 1'b0;
                    cnt_q <= cnt_q - ONE;
                end else begin
                    cnt_q <= cnt_q + ONE;
                end
            end else if (cnt_q == '0) begin
                up_q  <= 1'b1;
                cnt_q <= ONE;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign count_o      = cnt_q;
    assign dir_up_o     = up_q;
    assign top_evt_o    = step & up_q & (cnt_q >= top_val);
    assign bottom_evt_o = step & ~up_q & (cnt_q == '0);

    assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count_o == $past(count_o) + ONE) || (count_o == $past(count_o) - ONE));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count_o));
    assert_bottom_turn_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bottom_evt_o |=> (count_o == ONE) && dir_up_o);
    assert_top_turn_R11: assert property (@(posedge clk) disable iff (!rst_n)
        top_evt_o |=> !dir_up_o);
endmodule

// File: rtl/dspwm_shadow.sv
// Working copies of TOP and the two compare values, loaded from the pending
// inputs when load is high. It also picks the TOP source and clamps TOP to
// at least MIN_TOP.
module dspwm_shadow #(
    parameter int W       = dspwm_pkg::CNT_W,
    parameter int MIN_TOP = dspwm_pkg::MIN_TOP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         src_a,
    input  logic [W-1:0] top_in,
    input  logic [W-1:0] cmp_a_in,
    input  logic [W-1:0] cmp_b_in,
    output logic [W-1:0] top_q,
    output logic [W-1:0] cmp_a_q,
    output logic [W-1:0] cmp_b_q,
    output logic [W-1:0] top_val
);
    localparam logic [W-1:0] MINV = W'(MIN_TOP);

    logic [W-1:0] raw_top;

    // Copy the pending values into the working registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q   <= '0;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
        end else if (load) begin
            top_q   <= top_in;
            cmp_a_q <= cmp_a_in;
            cmp_b_q <= cmp_b_in;
        end
    end

    // Select the TOP source and apply the lower bound.
    always_comb begin
        raw_top = src_a ? cmp_a_q : top_q;
        top_val = (raw_top < MINV) ? MINV : raw_top;
    end
endmodule

// File: rtl/dspwm_ocu.sv
// Compare output for one channel. It turns count, direction and the compare
// value into a registered pin level. The pin changes one clock after the
// counter state that decides it. TOGGLE_OK enables toggle-at-TOP for com=1.
module dspwm_ocu #(
    parameter int W         = dspwm_pkg::CNT_W,
    parameter bit TOGGLE_OK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dspwm_pkg::com_t  com,
    input  logic             toggle_en,
    input  logic [W-1:0]     count,
    input  logic             dir_up,
    input  logic [W-1:0]     ocr,
    input  logic [W-1:0]     top_val,
    input  logic             top_evt,
    output logic             wave_o
);
    import dspwm_pkg::*;

    logic lvl;

    // Non-inverted level: high in the symmetric band around BOTTOM.
    always_comb begin
        if (ocr == '0)           lvl = 1'b0;
        else if (ocr >= top_val) lvl = 1'b1;
        else if (dir_up)         lvl = (count <= ocr);
        else                     lvl = (count < ocr);
    end

    // Register the pin according to the compare-output mode.
    always_ff @(posedge clk) begin
        if (!rst_n) wave_o <= 1'b0;
        else begin
            case (com)
                COM_TOGGLE: wave_o <= (TOGGLE_OK && toggle_en) ? (wave_o ^ top_evt) : 1'b0;
                COM_NONINV: wave_o <= lvl;
                COM_INV:    wave_o <= ~lvl;
                default:    wave_o <= 1'b0;
            endcase
        end
    end

    assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (com == COM_OFF) |=> !wave_o);
    assert_full_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (com == COM_NONINV && ocr >= top_val) |=> wave_o);
    assert_zero_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (com == COM_NONINV && ocr == '0) |=> !wave_o);
endmodule

// File: rtl/dspwm_timer.sv
// Top of the dual-slope PWM timer. It decodes mode, picks the buffer load
// point (BOTTOM for frequency-correct, TOP for phase-correct, every clock
// while stopped) and joins prescaler, counter, shadow registers and the two
// compare outputs.
module dspwm_timer #(
    parameter int W       = dspwm_pkg::CNT_W,
    parameter int PRE_W   = dspwm_pkg::PRE_W,
    parameter int MIN_TOP = dspwm_pkg::MIN_TOP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   clk_sel,
    input  logic [3:0]   mode,
    input  logic [1:0]   com_a,
    input  logic [1:0]   com_b,
    input  logic [W-1:0] top_in,
    input  logic [W-1:0] cmp_a_in,
    input  logic [W-1:0] cmp_b_in,
    output logic         wave_a,
    output logic         wave_b,
    output logic [W-1:0] count,
    output logic         top_evt,
    output logic         bottom_evt
);
    localparam int NCH = 2;

    logic         tick, sel_ok, mode_ok, pc_mode, src_a, run, step, load;
    logic         dir_up;
    logic [W-1:0] top_q, cmp_a_q, cmp_b_q, top_val;
    logic [W-1:0]    ocr_arr  [NCH];
    dspwm_pkg::com_t com_arr  [NCH];
    logic [NCH-1:0]  wave_arr;

    // Mode decode and load-point choice.
    always_comb begin
        mode_ok = (mode[3:2] == 2'b10);
        pc_mode = mode[1];
        src_a   = mode[0];
        run     = sel_ok & mode_ok;
        step    = tick & mode_ok;
        load    = ~run | (pc_mode ? top_evt : bottom_evt);
    end

    dspwm_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(clk_sel), .tick(tick), .valid(sel_ok));

    dspwm_shadow #(.W(W), .MIN_TOP(MIN_TOP)) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(load), .src_a(src_a),
        .top_in(top_in), .cmp_a_in(cmp_a_in), .cmp_b_in(cmp_b_in),
        .top_q(top_q), .cmp_a_q(cmp_a_q), .cmp_b_q(cmp_b_q), .top_val(top_val));

    dspwm_updown #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .top_val(top_val),
        .count_o(count), .dir_up_o(dir_up), .top_evt_o(top_evt),
        .bottom_evt_o(bottom_evt));

    assign ocr_arr[0] = cmp_a_q;
    assign ocr_arr[1] = cmp_b_q;
    assign com_arr[0] = com_a;
    assign com_arr[1] = com_b;

    // One compare output per channel; only channel A may toggle.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dspwm_ocu #(.W(W), .TOGGLE_OK(ch == 0)) u_ocu (
            .clk(clk), .rst_n(rst_n), .com(com_arr[ch]), .toggle_en(src_a),
            .count(count), .dir_up(dir_up), .ocr(ocr_arr[ch]),
            .top_val(top_val), .top_evt(top_evt), .wave_o(wave_arr[ch]));
    end

    assign wave_a = wave_arr[0];
    assign wave_b = wave_arr[1];

    assert_pfc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pc_mode && !bottom_evt) |=> $stable(top_q) && $stable(cmp_a_q) && $stable(cmp_b_q));
    assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pc_mode && !top_evt) |=> $stable(top_q) && $stable(cmp_a_q) && $stable(cmp_b_q));
endmodule

// File: tb/dspwm_timer_tb_top.sv
`timescale 1ns/1ps
module dspwm_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  clk_sel = 3'd0;
    logic [3:0]  mode = 4'd8;
    logic [1:0]  com_a = 2'd0, com_b = 2'd0;
    logic [15:0] top_in = 16'd0, cmp_a_in = 16'd0, cmp_b_in = 16'd0;
    logic        wave_a, wave_b, top_evt, bottom_evt;
    logic [15:0] count;

    int n_checks = 0;
    int n_fails  = 0;

    dspwm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .mode(mode),
        .com_a(com_a), .com_b(com_b), .top_in(top_in), .cmp_a_in(cmp_a_in),
        .cmp_b_in(cmp_b_in), .wave_a(wave_a), .wave_b(wave_b), .count(count),
        .top_evt(top_evt), .bottom_evt(bottom_evt));

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int div_of(input int sel);
        case (sel)
            1: return 1;    2: return 8;    3: return 64;
            4: return 256;  5: return 1024; default: return 0;
        endcase
    endfunction

    function automatic int clamp_top(input int t);
        return (t < 3) ? 3 : t;
    endfunction

    // High clocks per period for one channel (R4, R5, R6 for bits 0).
    function automatic int exp_high(input int com, input int ocr, input int t, input int n);
        int h;
        if (ocr == 0)      h = 0;
        else if (ocr >= t) h = 2 * t;
        else               h = 2 * ocr;
        if (com == 2) return h * n;
        if (com == 3) return (2 * t - h) * n;
        return 0;
    endfunction

    task automatic setup(input int sel, input int md, input int ca, input int cb,
                         input int t, input int a, input int b);
        @(negedge clk); clk_sel = 3'd0;
        @(negedge clk);
        mode = 4'(md); com_a = 2'(ca); com_b = 2'(cb);
        top_in = 16'(t); cmp_a_in = 16'(a); cmp_b_in = 16'(b);
        repeat (2) @(negedge clk);
        clk_sel = 3'(sel);
    endtask

    task automatic wait_bottom();
        do @(negedge clk); while (!bottom_evt);
    endtask

    task automatic wait_top();
        do @(negedge clk); while (!top_evt);
    endtask

    task automatic window(output int n, output int ha, output int hb);
        n = 0; ha = 0; hb = 0;
        do begin
            @(negedge clk);
            n++; ha += int'(wave_a); hb += int'(wave_b);
        end while (!bottom_evt);
    endtask

    // Configure, skip to a clean period, measure and compare.
    task automatic run_case(input string tag, input int sel, input int md,
                            input int ca, input int cb, input int t, input int a, input int b);
        int n, ha, hb, teff, nd;
        nd   = div_of(sel);
        teff = clamp_top((md == 9 || md == 11) ? a : t);
        setup(sel, md, ca, cb, t, a, b);
        wait_bottom();
        window(n, ha, hb);
        chk({tag, " R1 period"}, n, 2 * teff * nd);
        chk({tag, " R4/R5 channel A high"}, ha, exp_high(ca, a, teff, nd));
        chk({tag, " R4/R5 channel B high"}, hb, exp_high(cb, b, teff, nd));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int n, ha, hb, c0;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 count", int'(count), 0);
        chk("R12 wave_a", int'(wave_a), 0);
        chk("R12 wave_b", int'(wave_b), 0);
        chk("R12 strobes", int'(top_evt) + int'(bottom_evt), 0);

        // R4, R5 main function, frequency-correct, N=1
        run_case("basic", 1, 8, 2, 3, 20, 5, 5);
        // R4 extremes: zero and full compare values
        run_case("extreme", 1, 8, 2, 2, 20, 0, 20);
        run_case("extreme inv", 1, 8, 3, 2, 20, 0, 25);
        // R2 prescaler ratios
        run_case("div8", 2, 8, 2, 3, 5, 2, 4);
        run_case("div64", 3, 10, 2, 2, 3, 1, 2);
        run_case("div256", 4, 8, 3, 2, 3, 1, 2);
        run_case("div1024", 5, 8, 2, 0, 3, 1, 2);
        // R3 TOP from channel A compare value (mode 9)
        run_case("srcA", 1, 9, 2, 2, 30, 12, 6);
        // R10 TOP clamp
        run_case("R10 top=1", 1, 8, 2, 2, 1, 1, 2);
        run_case("R10 top=0", 1, 10, 2, 0, 0, 2, 0);

        // R2 stop encodings hold the count
        setup(1, 8, 2, 2, 20, 5, 5);
        repeat (7) @(negedge clk);
        clk_sel = 3'd6; c0 = int'(count);
        repeat (10) @(negedge clk);
        chk("R2 sel=6 holds count", int'(count), c0);
        clk_sel = 3'd0;
        repeat (10) @(negedge clk);
        chk("R2 sel=0 holds count", int'(count), c0);

        // R3 invalid mode holds the count
        setup(1, 4, 2, 2, 20, 5, 5);
        c0 = int'(count);
        repeat (10) @(negedge clk);
        chk("R3 invalid mode holds count", int'(count), c0);

        // R6 toggle on channel A with TOP from A (mode 11), bits 0 on B
        setup(1, 11, 1, 0, 40, 9, 3);
        wait_bottom();
        window(n, ha, hb);
        window(n, ha, hb);
        chk("R6 toggle window", n, 18);
        chk("R6 toggle half high", ha, 9);
        chk("R6 bits 0 low", hb, 0);
        window(n, ha, hb);
        chk("R6 toggle next half high", ha, 9);
        // R6 bits 1 without TOP from A: pin low
        run_case("R6 bits1 off", 1, 10, 1, 1, 12, 4, 4);

        // R7 frequency-correct TOP change while running
        setup(1, 8, 2, 2, 10, 4, 4);
        wait_bottom();
        n = 0;
        do begin
            @(negedge clk); n++;
            if (top_evt) top_in = 16'd7;
        end while (!bottom_evt);
        chk("R7 period during change keeps old TOP", n, 20);
        window(n, ha, hb);
        chk("R7 period after change", n, 14);
        chk("R7 duty after change", ha, 8);

        // R8 phase-correct TOP change while running
        setup(1, 10, 2, 2, 10, 4, 4);
        wait_bottom();
        top_in = 16'd6;
        wait_top();
        n = 0;
        do begin @(negedge clk); n++; end while (!top_evt);
        chk("R8 top-to-top across change", n, 16);
        n = 0;
        do begin @(negedge clk); n++; end while (!top_evt);
        chk("R8 top-to-top after change", n, 12);

        // R9 stopped timer loads buffers every clock
        setup(1, 8, 2, 2, 20, 5, 5);
        wait_bottom();
        repeat (3) @(negedge clk);
        clk_sel = 3'd0; top_in = 16'd8;
        repeat (2) @(negedge clk);
        clk_sel = 3'd1;
        wait_top();
        chk("R9 new TOP taken while stopped", int'(count), 8);
        // R11 strobe then count 1
        wait_bottom();
        @(negedge clk);
        chk("R11 count after bottom strobe", int'(count), 1);
        chk("R11 strobe lasts one clock", int'(bottom_evt), 0);

        // Random cases
        for (int i = 0; i < 12; i++) begin
            int t, a, b, md, ca, cb, sel;
            t   = $urandom_range(3, 30);
            a   = $urandom_range(0, t + 2);
            b   = $urandom_range(0, t + 2);
            md  = ($urandom_range(0, 1) == 0) ? 8 : 10;
            ca  = $urandom_range(2, 3);
            cb  = $urandom_range(2, 3);
            sel = $urandom_range(1, 2);
            run_case($sformatf("rand%0d", i), sel, md, ca, cb, t, a, b);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule